// File: doc/BRIEF.md
# Single-Source Shortest Path Engine

This block finds the least-cost routes from one source node to every other node of a directed graph whose links carry non-negative integer costs. The graph lives on chip as a table of arc records, each holding the sending node, the link cost and the receiving node. The records of one sending node sit in one contiguous group. Each node keeps an arc count and a group start address. The table can be edited while the block is idle: records are appended during a load phase and removed one at a time by an exact-match delete.

A load starts with `init_i`. Arcs are then presented with `entry_valid_i`, and `eof_i` starts the computation. A control state machine then alternates between two steps. The first is a linear scan that picks the unprocessed node with the smallest finite distance. The second walks that node's arcs one per cycle and relaxes each one. Distance, predecessor and processed flags are kept in separate per-node register arrays. When no finite unprocessed node remains, the engine returns to idle and raises `path_avail_o`, which means a result is ready. It then streams the route from the destination back to the source, one node per cycle.

Top module: `sp_engine`

## Requirements
- R1: After reset, `path_avail_o` and `path_valid_o` are 0, the arc table is empty, every distance is all-ones (infinity) and `dst_dist_o` reads all-ones.
- R2: While idle, `init_i` enters the load phase and clears `path_avail_o`. In the load phase, each `entry_valid_i` cycle appends one arc record. With `new_node_i`=1 the record opens the group of its sending node, setting that node's start to the record's address and its count to 1. With `new_node_i`=0 it adds one to the sending node's count.
- R3: `eof_i` in the load phase latches `src_i` and `dst_i`, sets every distance to infinity, every predecessor to 0 and every processed flag to 0, sets the source distance to 0, and starts the computation.
- R4: The selection step picks, among unprocessed nodes with finite distance, the one with the smallest distance. On a tie, the lowest node number wins. The picked node is marked processed.
- R5: The relaxation step takes the selected node's arcs in table order. Each arc whose new sum is strictly less than the receiving node's distance overwrites that distance and sets its predecessor to the selected node. No other write reaches the predecessor array.
- R6: The sum of a distance and a cost clamps at all-ones, so a route whose cost would reach or exceed all-ones leaves its node unreachable. The sum never wraps.
- R7: When no unprocessed node with finite distance remains, the engine returns to idle and sets `path_avail_o`. `dst_dist_o` then shows the destination's distance, which is all-ones when the destination is unreachable.
- R8: After a result, the route streams out as one `path_valid_o` beat per cycle. It starts at the destination and follows predecessors, and the beat holding the source has `path_last_o`=1. There are no beats when the destination is unreachable, and there is one beat when the destination equals the source.
- R9: `del_i` in idle or load removes the lowest-addressed record that equals `arc_from_i`/`arc_cost_i`/`arc_to_i`. Later records move down one place, the sending node's count drops by one, and later group starts drop by one. `path_avail_o` clears. The engine returns to idle once `del_i` falls. A delete with no matching record leaves the table as it was.
- R10: Once the table holds DEPTH records, further appends are ignored.
- R11: While computing, `init_i`, `del_i`, `entry_valid_i` and `eof_i` have no effect on the table or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Start a load phase from idle |
| entry_valid_i | input | 1 | Append the presented arc in the load phase |
| new_node_i | input | 1 | The presented arc opens its sending node's group |
| del_i | input | 1 | Delete the presented arc (idle or load) |
| eof_i | input | 1 | End of load; start the computation |
| arc_from_i | input | NODE_W | Sending node of the presented arc |
| arc_cost_i | input | COST_W | Link cost of the presented arc |
| arc_to_i | input | NODE_W | Receiving node of the presented arc |
| src_i | input | NODE_W | Source node, latched at end of load |
| dst_i | input | NODE_W | Destination node, latched at end of load |
| path_avail_o | output | 1 | Result ready |
| dst_dist_o | output | DIST_W | Distance label of the destination |
| path_valid_o | output | 1 | Route beat valid |
| path_node_o | output | NODE_W | Node of the current route beat |
| path_last_o | output | 1 | Current beat holds the source node |

## Verification
The assertions rely on a few input assumptions. Each sending node's arcs are loaded as one contiguous group that is opened once with `new_node_i`. Link costs are never wider than the distance label. No command is issued while a route is still streaming out. Given these, the predecessor chain always ends at the source, and the source's label stays at zero. The stimulus loads every node's arcs as a single group, and it waits for the last route beat before issuing the next command. Its only out-of-phase command pulses are made on purpose during computation, to show they are ignored.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    ST_RESET,
    ST_IDLE,
    ST_ADD,
    ST_SELECT,
    ST_UPDATE,
    ST_DELETE
  } sp_state_e;
endpackage

// File: rtl/sp_arc_table.sv
module sp_arc_table #(
  parameter int  NODE_W  = 3,
  parameter int  COST_W  = 8,
  parameter int  DEPTH   = 16,
  localparam int N_NODES = 1 << NODE_W,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic              wr_new_i,
  input  logic              del_i,
  input  logic [NODE_W-1:0] from_i,
  input  logic [COST_W-1:0] cost_i,
  input  logic [NODE_W-1:0] to_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [COST_W-1:0] rd_cost_o,
  output logic [NODE_W-1:0] rd_to_o,
  input  logic [NODE_W-1:0] q_node_i,
  output logic [ADDR_W-1:0] q_start_o,
  output logic [CNT_W-1:0]  q_cnt_o
);
  logic [NODE_W-1:0] from_q [DEPTH];
  logic [COST_W-1:0] cost_q [DEPTH];
  logic [NODE_W-1:0] to_q   [DEPTH];
  logic [ADDR_W-1:0] start_q [N_NODES];
  logic [CNT_W-1:0]  cnt_q   [N_NODES];
  logic [CNT_W-1:0]  fill_q;
  logic [DEPTH-1:0]  match;
  logic              full;
  logic              hit_any;
  logic [ADDR_W-1:0] hit_idx;

  assign full = (fill_q == CNT_W'(DEPTH));

  for (genvar k = 0; k < DEPTH; k++) begin : g_match
    assign match[k] = (CNT_W'(k) < fill_q) && (from_q[k] == from_i) &&
                      (cost_q[k] == cost_i) && (to_q[k] == to_i);
  end

  // lowest matching address wins
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_any = 1'b1;
        hit_idx = ADDR_W'(k);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        from_q[k] <= '0;
        cost_q[k] <= '0;
        to_q[k]   <= '0;
      end
      for (int n = 0; n < N_NODES; n++) begin
        start_q[n] <= '0;
        cnt_q[n]   <= '0;
      end
    end else if (clear_i) begin
      fill_q <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        from_q[k] <= '0;
        cost_q[k] <= '0;
        to_q[k]   <= '0;
      end
      for (int n = 0; n < N_NODES; n++) begin
        start_q[n] <= '0;
        cnt_q[n]   <= '0;
      end
    end else if (del_i) begin
      if (hit_any) begin
        for (int k = 0; k < DEPTH - 1; k++) begin
          if (ADDR_W'(k) >= hit_idx) begin
            from_q[k] <= from_q[k+1];
            cost_q[k] <= cost_q[k+1];
            to_q[k]   <= to_q[k+1];
          end
        end
        fill_q        <= fill_q - CNT_W'(1);
        cnt_q[from_i] <= cnt_q[from_i] - CNT_W'(1);
        for (int n = 0; n < N_NODES; n++) begin
          if (start_q[n] > hit_idx) start_q[n] <= start_q[n] - ADDR_W'(1);
        end
      end
    end else if (wr_i && !full) begin
      from_q[fill_q[ADDR_W-1:0]] <= from_i;
      cost_q[fill_q[ADDR_W-1:0]] <= cost_i;
      to_q[fill_q[ADDR_W-1:0]]   <= to_i;
      fill_q <= fill_q + CNT_W'(1);
      if (wr_new_i) begin
        start_q[from_i] <= fill_q[ADDR_W-1:0];
        cnt_q[from_i]   <= CNT_W'(1);
      end else begin
        cnt_q[from_i] <= cnt_q[from_i] + CNT_W'(1);
      end
    end
  end

  assign rd_cost_o = cost_q[rd_addr_i];
  assign rd_to_o   = to_q[rd_addr_i];
  assign q_start_o = start_q[q_node_i];
  assign q_cnt_o   = cnt_q[q_node_i];

  // R9: a hit shrinks the table by exactly one record
  a_r9_del_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (del_i && hit_any && !clear_i) |=> (fill_q == $past(fill_q) - CNT_W'(1)));

  // R10: appends to a full table leave the fill level alone
  a_r10_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full && !del_i && !clear_i) |=> $stable(fill_q));
endmodule

// File: rtl/sp_min_scan.sv
module sp_min_scan #(
  parameter int NODE_W  = 3,
  parameter int DIST_W  = 10,
  parameter int N_NODES = 8
) (
  input  logic [DIST_W-1:0]  dist_i [N_NODES],
  input  logic [N_NODES-1:0] done_i,
  output logic               found_o,
  output logic [NODE_W-1:0]  idx_o,
  output logic [DIST_W-1:0]  min_o
);
  localparam logic [DIST_W-1:0] INF = '1;

  // strict compare keeps the lowest index on ties; INF never beats INF
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    min_o   = INF;
    for (int n = 0; n < N_NODES; n++) begin
      if (!done_i[n] && (dist_i[n] < min_o)) begin
        found_o = 1'b1;
        idx_o   = NODE_W'(n);
        min_o   = dist_i[n];
      end
    end
  end
endmodule

// File: rtl/sp_path_walk.sv
module sp_path_walk #(
  parameter int NODE_W  = 3,
  parameter int N_NODES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              reach_i,
  input  logic [NODE_W-1:0] src_i,
  input  logic [NODE_W-1:0] dst_i,
  input  logic [NODE_W-1:0] pred_i [N_NODES],
  output logic              valid_o,
  output logic [NODE_W-1:0] node_o,
  output logic              last_o
);
  logic              active_q;
  logic [NODE_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cur_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
    end else if (start_i) begin
      active_q <= reach_i;
      cur_q    <= dst_i;
    end else if (active_q) begin
      if (cur_q == src_i) active_q <= 1'b0;
      else                cur_q    <= pred_i[cur_q];
    end
  end

  assign valid_o = active_q;
  assign node_o  = cur_q;
  assign last_o  = active_q && (cur_q == src_i);

  // R8: the source beat closes the stream
  a_r8_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o);
endmodule

// File: rtl/sp_engine.sv
module sp_engine
  import sp_pkg::*;
#(
  parameter int NODE_W = 3,
  parameter int COST_W = 8,
  parameter int DIST_W = 10,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              entry_valid_i,
  input  logic              new_node_i,
  input  logic              del_i,
  input  logic              eof_i,
  input  logic [NODE_W-1:0] arc_from_i,
  input  logic [COST_W-1:0] arc_cost_i,
  input  logic [NODE_W-1:0] arc_to_i,
  input  logic [NODE_W-1:0] src_i,
  input  logic [NODE_W-1:0] dst_i,
  output logic              path_avail_o,
  output logic [DIST_W-1:0] dst_dist_o,
  output logic              path_valid_o,
  output logic [NODE_W-1:0] path_node_o,
  output logic              path_last_o
);
  localparam int N_NODES = 1 << NODE_W;
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int SUM_W   = DIST_W + 1;
  localparam logic [DIST_W-1:0] INF = '1;

  sp_state_e          state_q;
  logic [NODE_W-1:0]  src_q, dst_q, sel_q;
  logic [DIST_W-1:0]  sel_dist_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic [CNT_W-1:0]   rem_q;
  logic               avail_q;
  logic [DIST_W-1:0]  dist_q [N_NODES];
  logic [NODE_W-1:0]  pred_q [N_NODES];
  logic [N_NODES-1:0] done_q;

  logic              cmd_ok, tbl_clear, tbl_wr, tbl_del;
  logic [COST_W-1:0] arc_cost;
  logic [NODE_W-1:0] arc_to;
  logic [ADDR_W-1:0] q_start;
  logic [CNT_W-1:0]  q_cnt;
  logic              scan_found;
  logic [NODE_W-1:0] scan_idx;
  logic [DIST_W-1:0] scan_min;
  logic [SUM_W-1:0]  sum;
  logic [DIST_W-1:0] relax_dist;
  logic              relax_we;
  logic              walk_start, walk_abort;

  assign cmd_ok    = (state_q == ST_IDLE) || (state_q == ST_ADD);
  assign tbl_clear = (state_q == ST_RESET);
  assign tbl_del   = cmd_ok && del_i;
  assign tbl_wr    = (state_q == ST_ADD) && !del_i && !eof_i && entry_valid_i;

  sp_arc_table #(.NODE_W(NODE_W), .COST_W(COST_W), .DEPTH(DEPTH)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (tbl_clear),
    .wr_i      (tbl_wr),
    .wr_new_i  (new_node_i),
    .del_i     (tbl_del),
    .from_i    (arc_from_i),
    .cost_i    (arc_cost_i),
    .to_i      (arc_to_i),
    .rd_addr_i (ptr_q),
    .rd_cost_o (arc_cost),
    .rd_to_o   (arc_to),
    .q_node_i  (scan_idx),
    .q_start_o (q_start),
    .q_cnt_o   (q_cnt)
  );

  sp_min_scan #(.NODE_W(NODE_W), .DIST_W(DIST_W), .N_NODES(N_NODES)) u_scan (
    .dist_i  (dist_q),
    .done_i  (done_q),
    .found_o (scan_found),
    .idx_o   (scan_idx),
    .min_o   (scan_min)
  );

  // saturating relaxation
  assign sum        = {1'b0, sel_dist_q} + SUM_W'(arc_cost);
  assign relax_dist = (sum >= {1'b0, INF}) ? INF : sum[DIST_W-1:0];
  assign relax_we   = (state_q == ST_UPDATE) && (rem_q != '0) &&
                      (relax_dist < dist_q[arc_to]);

  assign walk_start = (state_q == ST_SELECT) && !scan_found;
  assign walk_abort = (state_q == ST_IDLE) && (init_i || del_i);

  sp_path_walk #(.NODE_W(NODE_W), .N_NODES(N_NODES)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (walk_start),
    .abort_i (walk_abort),
    .reach_i (dist_q[dst_q] != INF),
    .src_i   (src_q),
    .dst_i   (dst_q),
    .pred_i  (pred_q),
    .valid_o (path_valid_o),
    .node_o  (path_node_o),
    .last_o  (path_last_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RESET;
      src_q      <= '0;
      dst_q      <= '0;
      sel_q      <= '0;
      sel_dist_q <= '0;
      ptr_q      <= '0;
      rem_q      <= '0;
      avail_q    <= 1'b0;
      done_q     <= '0;
      for (int n = 0; n < N_NODES; n++) begin
        dist_q[n] <= INF;
        pred_q[n] <= '0;
      end
    end else begin
      unique case (state_q)
        ST_RESET: begin
          avail_q <= 1'b0;
          done_q  <= '0;
          for (int n = 0; n < N_NODES; n++) begin
            dist_q[n] <= INF;
            pred_q[n] <= '0;
          end
          state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (del_i) begin
            avail_q <= 1'b0;
            state_q <= ST_DELETE;
          end else if (init_i) begin
            avail_q <= 1'b0;
            state_q <= ST_ADD;
          end
        end
        ST_ADD: begin
          if (del_i) begin
            state_q <= ST_DELETE;
          end else if (eof_i) begin
            src_q  <= src_i;
            dst_q  <= dst_i;
            done_q <= '0;
            for (int n = 0; n < N_NODES; n++) begin
              dist_q[n] <= INF;
              pred_q[n] <= '0;
            end
            dist_q[src_i] <= '0;
            state_q       <= ST_SELECT;
          end
        end
        ST_DELETE: begin
          if (!del_i) state_q <= ST_IDLE;
        end
        ST_SELECT: begin
          if (scan_found) begin
            sel_q            <= scan_idx;
            sel_dist_q       <= scan_min;
            done_q[scan_idx] <= 1'b1;
            ptr_q            <= q_start;
            rem_q            <= q_cnt;
            state_q          <= ST_UPDATE;
          end else begin
            avail_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_UPDATE: begin
          if (rem_q == '0) begin
            state_q <= ST_SELECT;
          end else begin
            if (relax_we) begin
              dist_q[arc_to] <= relax_dist;
              pred_q[arc_to] <= sel_q;
            end
            ptr_q <= ptr_q + ADDR_W'(1);
            rem_q <= rem_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_RESET;
      endcase
    end
  end

  assign path_avail_o = avail_q;
  assign dst_dist_o   = dist_q[dst_q];

  // R7: a result only appears at the end of a selection pass
  a_r7_avail_from_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avail_q) |-> ($past(state_q) == ST_SELECT));

  // R3: the source label stays zero throughout the computation
  a_r3_src_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SELECT) || (state_q == ST_UPDATE)) |-> (dist_q[src_q] == '0));

  // R4: the scan only offers unprocessed, reachable nodes
  a_r4_scan_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SELECT) && scan_found) |-> (!done_q[scan_idx] && (dist_q[scan_idx] != INF)));

  // R4: a processed node keeps its label while its arcs are walked
  a_r4_sel_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UPDATE) |-> (done_q[sel_q] && (dist_q[sel_q] == sel_dist_q)));
endmodule

// File: tb/sim_sp_engine.sv
`timescale 1ns/1ps
module sim_sp_engine;
  localparam int NODE_W = 3;
  localparam int COST_W = 8;
  localparam int DIST_W = 10;
  localparam int DEPTH  = 16;
  localparam int N_NODES = 1 << NODE_W;
  localparam int INF = (1 << DIST_W) - 1;
  localparam int LASTF = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic init_i = 1'b0, entry_valid_i = 1'b0, new_node_i = 1'b0, del_i = 1'b0, eof_i = 1'b0;
  logic [NODE_W-1:0] arc_from_i = '0, arc_to_i = '0, src_i = '0, dst_i = '0;
  logic [COST_W-1:0] arc_cost_i = '0;
  logic path_avail_o, path_valid_o, path_last_o;
  logic [DIST_W-1:0] dst_dist_o;
  logic [NODE_W-1:0] path_node_o;

  always #2.5 clk_i = ~clk_i;

  sp_engine #(.NODE_W(NODE_W), .COST_W(COST_W), .DIST_W(DIST_W), .DEPTH(DEPTH)) u0 (
    .clk_i, .rst_ni, .init_i, .entry_valid_i, .new_node_i, .del_i, .eof_i,
    .arc_from_i, .arc_cost_i, .arc_to_i, .src_i, .dst_i,
    .path_avail_o, .dst_dist_o, .path_valid_o, .path_node_o, .path_last_o
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int exp_q[$];
  int exp_dist;
  int m_from[$], m_cost[$], m_to[$];

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard for route beats (R8)
  always @(negedge clk_i) begin
    if (rst_ni && path_valid_o) begin
      int act;
      act = int'(path_node_o) + (path_last_o ? LASTF : 0);
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8 unexpected beat actual=%0d expected=none", act);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (act != e) begin
          n_fail++;
          $display("FAIL R8 route beat actual=%0d expected=%0d", act, e);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_from.delete(); m_cost.delete(); m_to.delete();
    exp_q.delete();
    tick(3);
    rst_ni = 1'b1;
    tick(2);
  endtask

  task automatic begin_load();
    @(negedge clk_i); init_i = 1'b1;
    @(negedge clk_i); init_i = 1'b0;
  endtask

  task automatic add_arc(int f, int c, int t, bit nn);
    @(negedge clk_i);
    arc_from_i = NODE_W'(f); arc_cost_i = COST_W'(c); arc_to_i = NODE_W'(t);
    new_node_i = nn; entry_valid_i = 1'b1;
    @(negedge clk_i);
    entry_valid_i = 1'b0; new_node_i = 1'b0;
    if (m_from.size() < DEPTH) begin
      m_from.push_back(f); m_cost.push_back(c); m_to.push_back(t);
    end
  endtask

  task automatic del_arc(int f, int c, int t);
    @(negedge clk_i);
    arc_from_i = NODE_W'(f); arc_cost_i = COST_W'(c); arc_to_i = NODE_W'(t);
    del_i = 1'b1;
    tick(2);
    del_i = 1'b0;
    tick(1);
    for (int k = 0; k < m_from.size(); k++) begin
      if (m_from[k] == f && m_cost[k] == c && m_to[k] == t) begin
        m_from.delete(k); m_cost.delete(k); m_to.delete(k);
        break;
      end
    end
  endtask

  // independent reference: lowest-index tie break, strict improvement, table order
  task automatic model(int src, int dst);
    int d[N_NODES];
    int p[N_NODES];
    bit dn[N_NODES];
    for (int n = 0; n < N_NODES; n++) begin d[n] = INF; p[n] = 0; dn[n] = 1'b0; end
    d[src] = 0;
    while (1) begin
      int sel;
      sel = -1;
      for (int n = 0; n < N_NODES; n++)
        if (!dn[n] && d[n] != INF && (sel < 0 || d[n] < d[sel])) sel = n;
      if (sel < 0) break;
      dn[sel] = 1'b1;
      for (int k = 0; k < m_from.size(); k++) begin
        if (m_from[k] == sel) begin
          int nd;
          nd = d[sel] + m_cost[k];
          if (nd >= INF) nd = INF;
          if (nd < d[m_to[k]]) begin d[m_to[k]] = nd; p[m_to[k]] = sel; end
        end
      end
    end
    exp_dist = d[dst];
    if (d[dst] != INF) begin
      int cur;
      cur = dst;
      while (1) begin
        if (cur == src) begin exp_q.push_back(cur + LASTF); break; end
        exp_q.push_back(cur);
        cur = p[cur];
      end
    end
  endtask

  task automatic run(string req, int src, int dst, bit noise);
    bit seen;
    seen = 1'b0;
    chk({req, " avail cleared by init (R2)"}, int'(path_avail_o), 0);
    model(src, dst);
    @(negedge clk_i);
    src_i = NODE_W'(src); dst_i = NODE_W'(dst); eof_i = 1'b1;
    @(negedge clk_i);
    eof_i = 1'b0;
    if (noise) begin
      // R11: commands during computation must be ignored
      arc_from_i = 3; arc_cost_i = 1; arc_to_i = 4;
      del_i = 1'b1; init_i = 1'b1; entry_valid_i = 1'b1; eof_i = 1'b1;
      tick(3);
      del_i = 1'b0; init_i = 1'b0; entry_valid_i = 1'b0; eof_i = 1'b0;
    end
    for (int i = 0; i < 4000; i++) begin
      if (path_avail_o) begin seen = 1'b1; break; end
      @(negedge clk_i);
    end
    chk({req, " R7 path_avail"}, int'(seen), 1);
    chk({req, " R7 dst_dist"}, int'(dst_dist_o), exp_dist);
    tick(N_NODES + 3);
    chk({req, " R8 beats outstanding"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic load_mesh();
    add_arc(0, 4, 1, 1); add_arc(0, 1, 2, 0); add_arc(0, 9, 5, 0);
    add_arc(1, 2, 3, 1); add_arc(1, 5, 4, 0);
    add_arc(2, 3, 1, 1); add_arc(2, 8, 3, 0);
    add_arc(3, 1, 4, 1); add_arc(3, 6, 5, 0);
    add_arc(4, 2, 5, 1);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 path_avail after reset", int'(path_avail_o), 0);
    chk("R1 path_valid after reset", int'(path_valid_o), 0);
    chk("R1 dst_dist after reset", int'(dst_dist_o), INF);
    // R1/R8: empty table, source equals destination
    begin_load(); run("R1 empty src=dst", 1, 1, 0);
    begin_load(); run("R1 empty unreachable", 1, 2, 0);

    // R2 R4 R5 R8: mesh graph
    begin_load(); load_mesh();
    run("R5 mesh dst4", 0, 4, 0);
    begin_load(); run("R4 mesh dst5", 0, 5, 0);
    begin_load(); run("R8 mesh dst0", 0, 0, 0);
    begin_load(); run("R7 mesh dst6", 0, 6, 0);
    begin_load(); run("R4 mesh src2", 2, 5, 0);

    // R9: delete from idle, then recompute
    del_arc(0, 9, 5);
    chk("R9 avail cleared by delete", int'(path_avail_o), 0);
    begin_load(); run("R9 after delete", 0, 5, 0);
    del_arc(0, 9, 5);
    begin_load(); run("R9 no-match delete", 0, 5, 0);
    del_arc(1, 2, 3);
    begin_load(); run("R9 mid-table delete", 0, 4, 0);
    // R9: delete from load phase
    begin_load(); del_arc(2, 8, 3);
    begin_load(); run("R9 delete in load", 0, 3, 0);

    // R11: noisy commands during computation
    do_reset();
    begin_load(); load_mesh();
    run("R11 noisy run", 0, 5, 1);
    begin_load(); run("R11 table intact", 0, 4, 0);

    // R6: saturation along a heavy chain
    do_reset();
    begin_load();
    for (int k = 0; k < 5; k++) add_arc(k, 255, k + 1, 1);
    run("R6 saturated node", 0, 5, 0);
    begin_load(); run("R6 largest finite", 0, 4, 0);

    // R10: overfill the table
    do_reset();
    begin_load();
    for (int k = 0; k < DEPTH + 2; k++) add_arc(0, 200 - k, 1 + (k % 7), k == 0);
    run("R10 full table", 0, 3, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule